// File: doc/BRIEF.md
# UART Modem Control and Serial Path Selector

This block holds the modem control register of one UART channel and the logic that the register drives. A host writes the register through a plain write strobe, and the register's current value is always available on a read bus. The register picks how the serial data travels: straight between the shift registers and the pins, turned back inside the chip for self-test, or through an external infrared encoder and decoder. In infrared mode it also sets the polarity of the infrared receive input.

The same register gates the interrupt request onto a tri-stateable output and drives a general-purpose output pin. It also picks whether the baud generator runs from the input clock directly or from a quarter of it. It produces the one-cycle clock enable that the baud generator uses.

An enhanced-features input guards two of the bits. When that input is low, the infrared enable bit and the prescaler bit are still stored and read back, but they have no effect. The register port carries no data stream, so it has no valid/ready handshake: a write lands on the clock edge where `reg_wr` is high, and reading needs no strobe.

Top module: `uart_modem_ctl`

## Requirements
- R1: All eight register bits reset to 0. After a write, `reg_rdata` returns the value written, every bit included, whatever `ext_en` is.
- R2: Normal mode applies when bit 4 is 0 and infrared mode is inactive. In normal mode `rx_bit` follows `rxd` and `txd` follows `tx_bit`.
- R3: When bit 3 is 0, `irq_oe` is 0 and `op2_n` is 1. When bit 3 is 1, `irq_oe` is 1 and `op2_n` is 0. `irq_out` always follows `irq_req`.
- R4: Local loopback applies when bit 4 is 1, and it takes precedence over infrared mode. In loopback `rx_bit` follows `tx_bit`, `txd` is held at 1, and `rxd` and `ir_dec_data` are ignored. The ring-indicator status `ri_flag` equals bit 2 in loopback and equals the inverse of `ri_n` otherwise.
- R5: Infrared mode is active only when bit 6 and `ext_en` are both 1. In infrared mode without loopback, `rx_bit` follows `ir_dec_data`, `ir_enc_data` follows `tx_bit`, `irtx` follows `ir_enc_pulse`, and `txd` is held at 1.
- R6: When infrared mode is inactive, or loopback is on, `irtx` is held at 0 and `ir_enc_data` is held at 1.
- R7: In infrared mode, `ir_dec_pulse` equals `irrx` when bit 2 is 0 and equals the inverse of `irrx` when bit 2 is 1. When infrared mode is inactive it is 0.
- R8: With bit 7 and `ext_en` both 1, `baud_ce` is high for exactly one cycle in every four. Otherwise `baud_ce` is high on every cycle after reset.
- R9: Once divide-by-four selection has been steady for five cycles, `baud_ce` is never high on two cycles in a row. A change of selection takes effect only at the counter's wrap point.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Current register value |
| ext_en | input | 1 | Enhanced-features enable |
| tx_bit | input | 1 | Serial data from transmit shift register |
| rx_bit | output | 1 | Serial data to receive shift register |
| txd | output | 1 | Serial transmit pin |
| rxd | input | 1 | Serial receive pin |
| ir_enc_data | output | 1 | Data to infrared encoder |
| ir_enc_pulse | input | 1 | Encoded pulse from infrared encoder |
| irtx | output | 1 | Infrared transmit pin |
| irrx | input | 1 | Infrared receive pin |
| ir_dec_pulse | output | 1 | Polarity-corrected pulse to infrared decoder |
| ir_dec_data | input | 1 | Decoded data from infrared decoder |
| ri_n | input | 1 | Ring-indicator pin, active low |
| ri_flag | output | 1 | Ring-indicator status towards status register |
| irq_req | input | 1 | Interrupt request from the channel |
| irq_out | output | 1 | Interrupt output data |
| irq_oe | output | 1 | Interrupt output drive enable |
| op2_n | output | 1 | General-purpose output, active low |
| baud_ce | output | 1 | Clock enable to baud generator |

## Verification
The register takes a write at the clock edge, and every pin and routing output is combinational from the register and the inputs. So each routing check is made at the falling edge after the write, once the pins have been set and have settled. `baud_ce` comes from a flop. A change to the prescaler bit can wait up to four cycles for the counter to wrap, so the bench lets eight cycles pass after each write before it counts enables over a sixteen-cycle window. The routing sweep covers all 256 register values, both settings of `ext_en` and every combination of the seven pin inputs.

// File: rtl/uart_mcr_pkg.sv
package uart_mcr_pkg;
  localparam int MCR_W       = 8;
  localparam int B_POLARITY  = 2;
  localparam int B_IRQ_GATE  = 3;
  localparam int B_LOOP      = 4;
  localparam int B_IR_EN     = 6;
  localparam int B_PRESCALE  = 7;

  typedef struct packed {
    logic loop_on;
    logic ir_on;
    logic ir_inv;
    logic irq_gate;
    logic div4_req;
  } mcr_ctl_t;
endpackage

// File: rtl/uart_mcr_regs.sv
module uart_mcr_regs
  import uart_mcr_pkg::*;
#(
  parameter int W = MCR_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  input  logic         ext_en,
  output logic [W-1:0] value,
  output mcr_ctl_t     ctl
);
  logic [W-1:0] mcr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  mcr_q <= '0;
    else if (wr) mcr_q <= wdata;
  end

  assign value = mcr_q;

  // enhanced-feature gating applies to decoded controls only, not readback
  always_comb begin
    ctl.loop_on  = mcr_q[B_LOOP];
    ctl.ir_on    = mcr_q[B_IR_EN] & ext_en;
    ctl.ir_inv   = mcr_q[B_POLARITY];
    ctl.irq_gate = mcr_q[B_IRQ_GATE];
    ctl.div4_req = mcr_q[B_PRESCALE] & ext_en;
  end
endmodule

// File: rtl/uart_mcr_route.sv
module uart_mcr_route
  import uart_mcr_pkg::*;
(
  input  mcr_ctl_t ctl,
  input  logic     tx_bit,
  output logic     rx_bit,
  output logic     txd,
  input  logic     rxd,
  output logic     ir_enc_data,
  input  logic     ir_enc_pulse,
  output logic     irtx,
  input  logic     irrx,
  output logic     ir_dec_pulse,
  input  logic     ir_dec_data,
  input  logic     ri_n,
  output logic     ri_flag
);
  logic ir_path;

  // loopback wins over infrared
  assign ir_path = ctl.ir_on & ~ctl.loop_on;

  always_comb begin
    if (ctl.loop_on)     rx_bit = tx_bit;
    else if (ctl.ir_on)  rx_bit = ir_dec_data;
    else                 rx_bit = rxd;

    txd          = (ctl.loop_on | ctl.ir_on) ? 1'b1 : tx_bit;
    ir_enc_data  = ir_path ? tx_bit : 1'b1;
    irtx         = ir_path ? ir_enc_pulse : 1'b0;
    ir_dec_pulse = ctl.ir_on ? (irrx ^ ctl.ir_inv) : 1'b0;
    ri_flag      = ctl.loop_on ? ctl.ir_inv : ~ri_n;
  end
endmodule

// File: rtl/uart_mcr_prescale.sv
module uart_mcr_prescale #(
  parameter int DIV   = 4,
  localparam int CNT_W = (DIV > 1) ? $clog2(DIV) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic div_req,
  output logic ce
);
  logic [CNT_W-1:0] cnt_q;
  logic             sel_q;
  logic             sel_eff;
  logic             wrap;
  logic             ce_q;

  assign wrap    = (cnt_q == CNT_W'(DIV - 1));
  // selection only changes at the wrap point: no short gaps
  assign sel_eff = wrap ? div_req : sel_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sel_q <= 1'b0;
      ce_q  <= 1'b0;
    end else begin
      cnt_q <= wrap ? '0 : cnt_q + 1'b1;
      sel_q <= sel_eff;
      ce_q  <= sel_eff ? wrap : 1'b1;
    end
  end

  assign ce = ce_q;
endmodule

// File: rtl/uart_modem_ctl.sv
module uart_modem_ctl
  import uart_mcr_pkg::*;
#(
  parameter int PRESCALE_DIV = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_wr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       ext_en,
  input  logic       tx_bit,
  output logic       rx_bit,
  output logic       txd,
  input  logic       rxd,
  output logic       ir_enc_data,
  input  logic       ir_enc_pulse,
  output logic       irtx,
  input  logic       irrx,
  output logic       ir_dec_pulse,
  input  logic       ir_dec_data,
  input  logic       ri_n,
  output logic       ri_flag,
  input  logic       irq_req,
  output logic       irq_out,
  output logic       irq_oe,
  output logic       op2_n,
  output logic       baud_ce
);
  mcr_ctl_t ctl;

  uart_mcr_regs #(.W(MCR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .wdata(reg_wdata),
    .ext_en(ext_en), .value(reg_rdata), .ctl(ctl)
  );

  uart_mcr_route u_route (
    .ctl(ctl), .tx_bit(tx_bit), .rx_bit(rx_bit), .txd(txd), .rxd(rxd),
    .ir_enc_data(ir_enc_data), .ir_enc_pulse(ir_enc_pulse), .irtx(irtx),
    .irrx(irrx), .ir_dec_pulse(ir_dec_pulse), .ir_dec_data(ir_dec_data),
    .ri_n(ri_n), .ri_flag(ri_flag)
  );

  uart_mcr_prescale #(.DIV(PRESCALE_DIV)) u_presc (
    .clk(clk), .rst_n(rst_n), .div_req(ctl.div4_req), .ce(baud_ce)
  );

  // one bit gates the interrupt driver and sets the spare output
  assign irq_out = irq_req;
  assign irq_oe  = ctl.irq_gate;
  assign op2_n   = ~ctl.irq_gate;
endmodule

// File: rtl/uart_modem_ctl_chk.sv
module uart_modem_ctl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       reg_wr,
  input logic [7:0] reg_wdata,
  input logic [7:0] reg_rdata,
  input logic       ext_en,
  input logic       tx_bit,
  input logic       rx_bit,
  input logic       txd,
  input logic       irtx,
  input logic       ri_flag,
  input logic       irq_oe,
  input logic       op2_n,
  input logic       baud_ce
);
  logic [2:0] div_steady;
  logic       div_want;

  assign div_want = reg_rdata[7] & ext_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             div_steady <= '0;
    else if (!div_want)     div_steady <= '0;
    else if (div_steady != 3'd7) div_steady <= div_steady + 1'b1;
  end

  p_readback_r1: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |=> reg_rdata == $past(reg_wdata));

  p_irq_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    irq_oe == reg_rdata[3] && op2_n == !reg_rdata[3]);

  p_loop_tx_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[4] |-> (txd && rx_bit == tx_bit && ri_flag == reg_rdata[2]));

  p_ir_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!(reg_rdata[6] && ext_en) || reg_rdata[4]) |-> !irtx);

  p_no_adjacent_ce_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (div_steady >= 3'd5 && div_want && baud_ce) |=> !baud_ce);
endmodule

bind uart_modem_ctl uart_modem_ctl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
  .reg_rdata(reg_rdata), .ext_en(ext_en), .tx_bit(tx_bit),
  .rx_bit(rx_bit), .txd(txd), .irtx(irtx), .ri_flag(ri_flag),
  .irq_oe(irq_oe), .op2_n(op2_n), .baud_ce(baud_ce)
);

// File: tb/uart_modem_ctl_test.sv
`timescale 1ns/1ps
module uart_modem_ctl_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic ext_en = 1'b0;
  logic tx_bit = 1'b1, rxd = 1'b1, ir_enc_pulse = 1'b0, irrx = 1'b0;
  logic ir_dec_data = 1'b1, ri_n = 1'b1, irq_req = 1'b0;
  logic rx_bit, txd, ir_enc_data, irtx, ir_dec_pulse, ri_flag;
  logic irq_out, irq_oe, op2_n, baud_ce;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  uart_modem_ctl uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .ext_en(ext_en), .tx_bit(tx_bit),
    .rx_bit(rx_bit), .txd(txd), .rxd(rxd), .ir_enc_data(ir_enc_data),
    .ir_enc_pulse(ir_enc_pulse), .irtx(irtx), .irrx(irrx),
    .ir_dec_pulse(ir_dec_pulse), .ir_dec_data(ir_dec_data), .ri_n(ri_n),
    .ri_flag(ri_flag), .irq_req(irq_req), .irq_out(irq_out),
    .irq_oe(irq_oe), .op2_n(op2_n), .baud_ce(baud_ce)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [7:0] v);
    @(negedge clk);
    reg_wr = 1'b1;
    reg_wdata = v;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic count_ce(output int n);
    n = 0;
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      if (baud_ce) n++;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state, R3 reset outputs, R8 undivided enable
    chk("R1 reset value", reg_rdata, 0);
    chk("R3 reset irq_oe", irq_oe, 0);
    chk("R3 reset op2_n", op2_n, 1);
    chk("R2 reset txd", txd, tx_bit);
    count_ce(n);
    chk("R8 reset ce count", n, 16);

    for (int e = 0; e < 2; e++) begin
      for (int v = 0; v < 256; v++) begin
        logic [7:0] m;
        logic lp, ir;
        m = 8'(v);
        ext_en = e[0];
        wr_reg(m);
        chk("R1 readback", reg_rdata, v);
        lp = m[4];
        ir = m[6] & e[0];
        for (int p = 0; p < 128; p++) begin
          logic [6:0] pv;
          logic x_rx;
          pv = 7'(p);
          {irq_req, ri_n, ir_enc_pulse, ir_dec_data, irrx, rxd, tx_bit} = pv;
          #1;
          x_rx = lp ? pv[0] : (ir ? pv[3] : pv[1]);
          if (lp) chk("R4 loop rx", rx_bit, x_rx);
          else if (ir) chk("R5 ir rx", rx_bit, x_rx);
          else chk("R2 normal rx", rx_bit, x_rx);
          if (lp) chk("R4 loop txd", txd, 1);
          else if (ir) chk("R5 ir txd", txd, 1);
          else chk("R2 normal txd", txd, pv[0]);
          if (ir && !lp) begin
            chk("R5 ir_enc_data", ir_enc_data, pv[0]);
            chk("R5 irtx", irtx, pv[4]);
          end else begin
            chk("R6 ir_enc_data idle", ir_enc_data, 1);
            chk("R6 irtx idle", irtx, 0);
          end
          chk("R7 ir_dec_pulse", ir_dec_pulse, ir ? (pv[2] ^ m[2]) : 0);
          chk("R4 ri_flag", ri_flag, lp ? m[2] : !pv[5]);
          chk("R3 irq_oe", irq_oe, m[3]);
          chk("R3 op2_n", op2_n, !m[3]);
          chk("R3 irq_out", irq_out, pv[6]);
        end
      end
    end

    // prescaler sweep: R8 and R9
    for (int k = 0; k < 8; k++) begin
      logic b7, ee;
      b7 = k[0];
      ee = k[1];
      ext_en = ee;
      wr_reg({b7, 7'h00});
      repeat (8) @(negedge clk);
      count_ce(n);
      chk("R8 ce count", n, (b7 && ee) ? 4 : 16);
      if (b7 && ee) begin
        int gap;
        int last;
        gap = 0;
        last = -1;
        for (int i = 0; i < 12; i++) begin
          @(negedge clk);
          if (baud_ce) begin
            if (last >= 0) gap = i - last;
            last = i;
          end
        end
        chk("R9 ce spacing", gap, 4);
      end
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule